// File: doc/BRIEF.md
# Wrapping Effective Address Generator

This block resolves the operand address for the indexed and pointer-based addressing modes of an 8-bit processor core. A core's decode stage raises a start strobe together with a mode code, the one or two operand bytes that follow the opcode, both index registers and the program counter value that already points past the operand. The block answers with a 16-bit effective address and a one-cycle valid pulse. Modes that need a pointer read it, low byte first, through a synchronous memory read port with one cycle of latency.

All pointer arithmetic stays inside one 256-byte page, reproducing the behaviour of the early NMOS silicon. A zero-page index sum drops its carry. A zero-page pointer at the last byte of page zero takes its upper byte from the first byte of page zero. An indirect jump through a pointer whose low byte is 0xFF takes its upper byte from offset 0x00 of the same page. Only the final add of Y in the post-indexed mode carries across pages. Fetching the operand data and executing the instruction belong to the caller.

Top module: `eag_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `ea_valid`, `rd_en` and `busy` are 0 and `ea` is 0x0000.
- R2: Mode code 0 (zero page indexed by X) gives `ea` = {0x00, (operand_low + X) mod 256}, with `ea_valid` high in the cycle after the start cycle and no memory read; operand 0x80 with X 0xFF gives 0x007F.
- R3: Mode code 4 (relative) gives `ea` = (pc_next + operand_low taken as a signed byte) mod 65536, so offsets 0x80 to 0xFF move backwards by 256 minus the offset, in the cycle after the start cycle with no memory read.
- R4: Mode code 1 (pre-indexed indirect) reads the pointer from {0x00, p} and {0x00, (p+1) mod 256} where p = (operand_low + X) mod 256, and `ea` = {high byte, low byte}; operand 0x80 with X 0xFF reads 0x007F then 0x0080.
- R5: Mode code 2 (post-indexed indirect) reads the pointer from {0x00, operand_low} and {0x00, (operand_low+1) mod 256}, and `ea` = (pointer + Y) mod 65536; operand 0xFF reads 0x00FF then 0x0000.
- R6: Mode code 3 (indirect jump) reads the pointer from {operand_high, operand_low} and {operand_high, (operand_low+1) mod 256}, and `ea` is that pointer unchanged; pointer 0x00FF takes its upper byte from 0x0000.
- R7: A pointer mode drives `rd_en` for exactly two consecutive cycles, low-byte address first; `rd_data` is taken one cycle after the address it answers, and `ea_valid` is high four cycles after the start cycle.
- R8: Each accepted start yields exactly one `ea_valid` cycle, and `busy` is low whenever `ea_valid` is high.
- R9: A start while `busy` is high is ignored: the running request completes with its own result and no extra valid pulse follows.
- R10: Mode codes 5, 6 and 7 are ignored: no `ea_valid` pulse and no memory read follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| mode | input | 3 | Addressing mode code |
| opnd_lo | input | 8 | First operand byte (zero-page address, offset or pointer low) |
| opnd_hi | input | 8 | Second operand byte (pointer high for indirect jump) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc_next | input | 16 | Program counter after the operand |
| rd_data | input | 8 | Read data, one cycle after the address |
| rd_en | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| ea | output | 16 | Effective address, held until the next result |
| ea_valid | output | 1 | One-cycle result strobe |
| busy | output | 1 | A pointer request is in progress |

## Verification
The assertions assume a memory that answers every read with exactly one cycle of latency and a reset held for at least one clock before the first request, so that the page-wrap and read-pairing properties compare against defined history. The bench memory returns an arithmetic hash of the address, which makes a read from the wrong page produce a different pointer, and it keeps its reset asserted for several cycles. Stimulus sweeps operand bytes and index values across the page edges, raises start during busy only to probe that it is ignored, and tries the unused mode codes only from idle.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    AM_ZPX  = 3'd0,
    AM_INDX = 3'd1,
    AM_INDY = 3'd2,
    AM_JIND = 3'd3,
    AM_REL  = 3'd4
  } am_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE_HI,
    ST_TAKE_LO,
    ST_TAKE_HI
  } st_e;

  // modes that need two pointer bytes from memory
  function automatic logic needs_ptr(input logic [2:0] m);
    return (m == AM_INDX) || (m == AM_INDY) || (m == AM_JIND);
  endfunction

  function automatic logic mode_known(input logic [2:0] m);
    return m <= AM_REL;
  endfunction

endpackage

// File: rtl/eag_ptr_addr.sv
// Addresses of the two pointer bytes; the second byte never leaves the page.
module eag_ptr_addr
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]          mode,
  input  logic [BYTE_W-1:0]   op_lo,
  input  logic [BYTE_W-1:0]   op_hi,
  input  logic [BYTE_W-1:0]   idx_x,
  output logic [2*BYTE_W-1:0] lo_addr,
  output logic [2*BYTE_W-1:0] hi_addr
);
  localparam logic [BYTE_W-1:0] ONE = {{(BYTE_W-1){1'b0}}, 1'b1};

  logic [BYTE_W-1:0] page;
  logic [BYTE_W-1:0] offs;
  logic [BYTE_W-1:0] offs_nxt;

  always_comb begin
    page = '0;
    offs = op_lo;
    case (mode)
      AM_INDX: offs = op_lo + idx_x;
      AM_INDY: offs = op_lo;
      AM_JIND: page = op_hi;
      default: offs = op_lo;
    endcase
  end

  assign offs_nxt = offs + ONE;
  assign lo_addr  = {page, offs};
  assign hi_addr  = {page, offs_nxt};

endmodule

// File: rtl/eag_direct.sv
// Modes resolved without memory: zero page + X, and relative branch target.
module eag_direct
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]          mode,
  input  logic [BYTE_W-1:0]   op_lo,
  input  logic [BYTE_W-1:0]   idx_x,
  input  logic [2*BYTE_W-1:0] pc_next,
  output logic [2*BYTE_W-1:0] ea
);
  logic [BYTE_W-1:0]   zp_sum;
  logic [2*BYTE_W-1:0] rel_ext;

  assign zp_sum  = op_lo + idx_x;
  assign rel_ext = {{BYTE_W{op_lo[BYTE_W-1]}}, op_lo};

  always_comb begin
    case (mode)
      AM_ZPX:  ea = {{BYTE_W{1'b0}}, zp_sum};
      AM_REL:  ea = pc_next + rel_ext;
      default: ea = '0;
    endcase
  end

endmodule

// File: rtl/eag_resolve.sv
// Final address from the assembled pointer; only post-indexing carries.
module eag_resolve
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]          mode,
  input  logic [2*BYTE_W-1:0] ptr,
  input  logic [BYTE_W-1:0]   idx_y,
  output logic [2*BYTE_W-1:0] ea
);
  always_comb begin
    if (mode == AM_INDY) ea = ptr + {{BYTE_W{1'b0}}, idx_y};
    else                 ea = ptr;
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [2:0]            mode,
  input  logic [BYTE_W-1:0]     opnd_lo,
  input  logic [BYTE_W-1:0]     opnd_hi,
  input  logic [BYTE_W-1:0]     idx_x,
  input  logic [BYTE_W-1:0]     idx_y,
  input  logic [2*BYTE_W-1:0]   pc_next,
  input  logic [BYTE_W-1:0]     rd_data,
  output logic                  rd_en,
  output logic [2*BYTE_W-1:0]   rd_addr,
  output logic [2*BYTE_W-1:0]   ea,
  output logic                  ea_valid,
  output logic                  busy
);
  localparam int AW = 2 * BYTE_W;

  st_e               st;
  logic [2:0]        mode_q;
  logic [BYTE_W-1:0] y_q;
  logic [BYTE_W-1:0] ptr_lo_q;
  logic [AW-1:0]     hi_addr_q;
  logic [AW-1:0]     ea_q;
  logic              valid_q;
  logic              rd_en_q;
  logic [AW-1:0]     rd_addr_q;

  logic [AW-1:0]     lo_addr_w;
  logic [AW-1:0]     hi_addr_w;
  logic [AW-1:0]     direct_ea;
  logic [AW-1:0]     resolved_ea;
  logic              accept;

  eag_ptr_addr #(.BYTE_W(BYTE_W)) u_ptr (
    .mode    (mode),
    .op_lo   (opnd_lo),
    .op_hi   (opnd_hi),
    .idx_x   (idx_x),
    .lo_addr (lo_addr_w),
    .hi_addr (hi_addr_w)
  );

  eag_direct #(.BYTE_W(BYTE_W)) u_direct (
    .mode    (mode),
    .op_lo   (opnd_lo),
    .idx_x   (idx_x),
    .pc_next (pc_next),
    .ea      (direct_ea)
  );

  eag_resolve #(.BYTE_W(BYTE_W)) u_resolve (
    .mode  (mode_q),
    .ptr   ({rd_data, ptr_lo_q}),
    .idx_y (y_q),
    .ea    (resolved_ea)
  );

  assign accept = start && (st == ST_IDLE) && mode_known(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mode_q    <= '0;
      y_q       <= '0;
      ptr_lo_q  <= '0;
      hi_addr_q <= '0;
      ea_q      <= '0;
      valid_q   <= 1'b0;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            mode_q <= mode;
            y_q    <= idx_y;
            if (needs_ptr(mode)) begin
              rd_en_q   <= 1'b1;
              rd_addr_q <= lo_addr_w;
              hi_addr_q <= hi_addr_w;
              st        <= ST_ISSUE_HI;
            end else begin
              ea_q    <= direct_ea;
              valid_q <= 1'b1;
            end
          end
        end
        ST_ISSUE_HI: begin
          rd_addr_q <= hi_addr_q;
          st        <= ST_TAKE_LO;
        end
        ST_TAKE_LO: begin
          rd_en_q  <= 1'b0;
          ptr_lo_q <= rd_data;
          st       <= ST_TAKE_HI;
        end
        ST_TAKE_HI: begin
          ea_q    <= resolved_ea;
          valid_q <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_en    = rd_en_q;
  assign rd_addr  = rd_addr_q;
  assign ea       = ea_q;
  assign ea_valid = valid_q;
  assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [2:0]          mode,
  input logic [2:0]          mode_q,
  input logic                busy,
  input logic                rd_en,
  input logic [2*BYTE_W-1:0] rd_addr,
  input logic                ea_valid
);
  localparam int AW = 2 * BYTE_W;

  logic [AW-1:0]     prev_addr;
  logic [BYTE_W-1:0] prev_lo_inc;

  always_ff @(posedge clk) prev_addr <= rd_addr;
  assign prev_lo_inc = prev_addr[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, 1'b1};

  assert_fetch_pair_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |=> rd_en);

  assert_fetch_end_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |=> !rd_en);

  // second pointer byte stays in the page of the first (R4, R5, R6)
  assert_same_page_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |->
      (rd_addr[AW-1:BYTE_W] == prev_addr[AW-1:BYTE_W]) &&
      (rd_addr[BYTE_W-1:0] == prev_lo_inc));

  // zero-page pointers never leave page zero (R4, R5)
  assert_zp_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (mode_q == 3'd1 || mode_q == 3'd2)) |-> (rd_addr[AW-1:BYTE_W] == '0));

  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ea_valid |-> !busy);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q));

  assert_bad_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode > 3'd4) |=> (!ea_valid && !rd_en));

endmodule

bind eag_top eag_checker #(.BYTE_W(BYTE_W)) u_eag_checker (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .mode     (mode),
  .mode_q   (mode_q),
  .busy     (busy),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .ea_valid (ea_valid)
);

// File: tb/test_eag_top.sv
`timescale 1ns/1ps
module test_eag_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc_next = '0;
  logic [7:0]  rd_data = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [15:0] ea;
  logic        ea_valid;
  logic        busy;

  int n_chk = 0;
  int n_err = 0;
  int rd_cnt = 0;
  logic [15:0] rd_log [0:3];

  always #10 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .pc_next(pc_next), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .ea(ea), .ea_valid(ea_valid), .busy(busy)
  );

  // memory content is a hash of the address: wrong page gives a different byte
  function automatic logic [7:0] mf(input logic [15:0] a);
    int v;
    v = int'(a[7:0]) * 3 + int'(a[15:8]) * 29 + 7;
    return v[7:0];
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mf(rd_addr);
      rd_log[rd_cnt % 4] <= rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic run(input logic [2:0] m, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                     input int exp_ea, input int exp_lat, input int exp_nrd,
                     input int a0, input int a1, input string req);
    int base;
    int lat;
    base = rd_cnt;
    @(negedge clk);
    mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc_next = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!ea_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    chk(ea_valid && lat == exp_lat, "R7", "valid latency", lat, exp_lat);
    chk(ea == exp_ea[15:0], req, "effective address", ea, exp_ea);
    if (exp_nrd == 2) begin
      chk(rd_log[base % 4] == a0[15:0], req, "first pointer read", rd_log[base % 4], a0);
      chk(rd_log[(base + 1) % 4] == a1[15:0], req, "second pointer read",
          rd_log[(base + 1) % 4], a1);
    end
    @(negedge clk);
    chk(!ea_valid, "R8", "valid width", ea_valid, 0);
    chk(rd_cnt - base == exp_nrd, req, "read count", rd_cnt - base, exp_nrd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    logic [7:0] xl [5];
    logic [7:0] yl [4];
    logic [15:0] pcl [3];
    xl = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    yl = '{8'h00, 8'h02, 8'h80, 8'hFF};
    pcl = '{16'h0002, 16'h1000, 16'hFFF0};

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!ea_valid && !rd_en && !busy && ea == 16'h0, "R1", "reset outputs",
        {ea_valid, rd_en, busy, ea}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ea_valid && !rd_en && !busy && ea == 16'h0, "R1", "after reset",
        {ea_valid, rd_en, busy, ea}, 0);

    // R2 zero page + X, including 0x80 + 0xFF -> 0x007F
    run(3'd0, 8'h80, 8'h00, 8'hFF, 8'h00, 16'h0, 16'h007F, 1, 0, 0, 0, "R2");
    for (int lo = 0; lo < 256; lo += 15)
      foreach (xl[i])
        run(3'd0, lo[7:0], 8'h00, xl[i], 8'h00, 16'h0, (lo + int'(xl[i])) % 256,
            1, 0, 0, 0, "R2");

    // R3 relative
    foreach (pcl[i])
      for (int off = 0; off < 256; off++)
        run(3'd4, off[7:0], 8'h00, 8'h00, 8'h00, pcl[i],
            (int'(pcl[i]) + (off >= 128 ? off - 256 : off)) & 32'hFFFF,
            1, 0, 0, 0, "R3");

    // R4 pre-indexed indirect
    for (int lo = 0; lo < 256; lo += 15)
      foreach (xl[i]) begin
        int p;
        p = (lo + int'(xl[i])) % 256;
        run(3'd1, lo[7:0], 8'h00, xl[i], 8'h00, 16'h0,
            int'(mf(16'(p))) + 256 * int'(mf(16'((p + 1) % 256))),
            4, 2, p, (p + 1) % 256, "R4");
      end
    run(3'd1, 8'h80, 8'h00, 8'hFF, 8'h00, 16'h0,
        int'(mf(16'h007F)) + 256 * int'(mf(16'h0080)), 4, 2, 16'h007F, 16'h0080, "R4");

    // R5 post-indexed indirect, including pointer at 0x00FF
    for (int lo = 0; lo < 256; lo += 15)
      foreach (yl[i]) begin
        int ptr;
        ptr = int'(mf(16'(lo))) + 256 * int'(mf(16'((lo + 1) % 256)));
        run(3'd2, lo[7:0], 8'h00, 8'h00, yl[i], 16'h0, (ptr + int'(yl[i])) & 32'hFFFF,
            4, 2, lo, (lo + 1) % 256, "R5");
      end

    // R6 indirect jump, page wrap at low byte 0xFF
    foreach (xl[i])
      for (int h = 0; h < 256; h += 127) begin
        int a0;
        int a1;
        a0 = h * 256 + int'(xl[i]);
        a1 = h * 256 + (int'(xl[i]) + 1) % 256;
        run(3'd3, xl[i], h[7:0], 8'h00, 8'h00, 16'h0,
            int'(mf(16'(a0))) + 256 * int'(mf(16'(a1))), 4, 2, a0, a1, "R6");
      end
    run(3'd3, 8'hFE, 8'h00, 8'h00, 8'h00, 16'h0,
        int'(mf(16'h00FE)) + 256 * int'(mf(16'h00FF)), 4, 2, 16'h00FE, 16'h00FF, "R6");

    // R9 start while busy is ignored
    begin
      int nv;
      int base;
      base = rd_cnt;
      @(negedge clk);
      mode = 3'd1; opnd_lo = 8'h80; idx_x = 8'hFF; start = 1'b1;
      @(negedge clk);
      mode = 3'd0; opnd_lo = 8'h11; idx_x = 8'h00;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(ea_valid, "R9", "valid of first request", ea_valid, 1);
      chk(ea == int'(mf(16'h007F)) + 256 * int'(mf(16'h0080)), "R9", "first result kept",
          ea, int'(mf(16'h007F)) + 256 * int'(mf(16'h0080)));
      nv = 0;
      repeat (5) begin
        @(negedge clk);
        if (ea_valid) nv++;
      end
      chk(nv == 0, "R9", "no extra valid", nv, 0);
      chk(rd_cnt - base == 2, "R9", "read count", rd_cnt - base, 2);
    end

    // R10 unused mode codes
    for (int m = 5; m < 8; m++) begin
      int nv;
      int base;
      base = rd_cnt;
      @(negedge clk);
      mode = m[2:0]; opnd_lo = 8'h40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nv = ea_valid ? 1 : 0;
      repeat (5) begin
        @(negedge clk);
        if (ea_valid) nv++;
      end
      chk(nv == 0, "R10", "no valid for unused mode", nv, 0);
      chk(rd_cnt == base, "R10", "no read for unused mode", rd_cnt - base, 0);
    end

    report();
  end
endmodule